// File: doc/BRIEF.md
# Aliased byte/word register file

This block is the register storage of a small accumulator processor. It keeps sixteen byte-wide registers, selected by a 4-bit index, and two word-wide registers, the program counter and the stack pointer. Four of the byte registers also act as the halves of two word-wide pairs. A 2-bit word index therefore reaches the program counter, the stack pointer and the two pairs.

The block has a byte read port, a byte write port, a word read port and a word write port. The datapath drives these ports during ordinary execution. A 3-bit operation input with a 4-bit operand carries out the register-only instructions directly: loading a nibble into the low or high half of the accumulator, copying the accumulator into any byte register, and copying one word register into another. Reads are combinational. Writes land on the rising clock edge. An active-low asynchronous reset clears every register.

Operation codes on `op_i`: 0 = none, 1 = low-nibble load, 2 = high-nibble load, 3 = copy accumulator, 4 = word copy. Codes 5 to 7 behave like 0.

Top module: `regfile_alias`

## Requirements
- R1: While `rst_ni` is low, every byte register, the program counter and the stack pointer read as zero. This holds after the first reset and after a reset applied later in the run.
- R2: A byte write with `wr8_en_i` high, on index 0 to 14, stores `wr8_data_i` at the next rising edge. The byte read port returns register `rd8_idx_i` combinationally. Index 0 is the accumulator and index 5 is the flags register.
- R3: Byte index 15 always reads zero. Any write to it, from any source, is discarded.
- R4: Word index 0 is the program counter and word index 1 is the stack pointer. Writing either one leaves all byte registers unchanged.
- R5: Word index 2 reads and writes {byte 8, byte 9}, high byte first. Word index 3 does the same for {byte 10, byte 11}. A write through either view is visible through the other.
- R6: A byte write and a word write in the same cycle that touch the same byte resolve in favour of the word write. Writes that do not overlap both take effect.
- R7: Code 1 replaces bits [3:0] of the accumulator with `operand_i` and keeps bits [7:4]. Code 2 replaces bits [7:4] and keeps bits [3:0].
- R8: Code 3 copies the accumulator into the byte register named by `operand_i`. When the operand is 15, the copy is discarded.
- R9: Code 4 writes the word register selected by `operand_i[3:2]` with the value, before the edge, of the word register selected by `operand_i[1:0]`.
- R10: While `op_i` is 1 to 4, the external byte and word write ports are ignored. With codes 5 to 7, those ports behave exactly as with code 0.
- R11: `acc_o` always shows byte register 0 and `flags_o` always shows byte register 5.
- R12: With both write enables low and `op_i` at 0, no register changes, whatever the data and index inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Register-only operation code |
| operand_i | input | 4 | Operand of the register-only operation |
| wr8_en_i | input | 1 | Byte write enable |
| wr8_idx_i | input | 4 | Byte write index |
| wr8_data_i | input | 8 | Byte write data |
| wr16_en_i | input | 1 | Word write enable |
| wr16_idx_i | input | 2 | Word write index |
| wr16_data_i | input | 16 | Word write data |
| rd8_idx_i | input | 4 | Byte read index |
| rd8_data_o | output | 8 | Byte read data |
| rd16_idx_i | input | 2 | Word read index |
| rd16_data_o | output | 16 | Word read data |
| acc_o | output | 8 | Accumulator contents |
| flags_o | output | 8 | Flags register contents |

## Verification
Every write source, whether an external port or an internal operation, has one register between its inputs and the outputs. Its result is therefore due right after the next rising edge. The only exception is reset, which clears everything as soon as it asserts. The bench changes inputs on the falling edge. It then waits for the rising edge, plus a small delay, before it drops the enables. After that it walks both read indices over every value and compares each result with a bench-side model. The read paths are combinational, so these samples need no extra wait, and the idle cycles in between cannot disturb the state.

// File: rtl/regfile_alias_pkg.sv
package regfile_alias_pkg;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned NUM_REGS = 1 << IDX_W;
  localparam int unsigned WIDX_W   = 2;
  localparam int unsigned NIB_W    = 4;

  localparam logic [IDX_W-1:0] IDX_ACC   = 4'd0;
  localparam logic [IDX_W-1:0] IDX_FLAGS = 4'd5;
  localparam logic [IDX_W-1:0] IDX_PAIR0 = 4'd8;
  localparam logic [IDX_W-1:0] IDX_ZERO  = 4'd15;

  localparam logic [WIDX_W-1:0] W_PC  = 2'd0;
  localparam logic [WIDX_W-1:0] W_SP  = 2'd1;
  localparam logic [WIDX_W-1:0] W_IJ  = 2'd2;
  localparam logic [WIDX_W-1:0] W_KL  = 2'd3;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_NIB_LO = 3'd1,
    OP_NIB_HI = 3'd2,
    OP_MOV_A  = 3'd3,
    OP_MOV_W  = 3'd4
  } op_e;
endpackage

// File: rtl/regfile_alias_op.sv
module regfile_alias_op
  import regfile_alias_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  operand_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [WORD_W-1:0] wsrc_i,
  input  logic              ext8_en_i,
  input  logic [IDX_W-1:0]  ext8_idx_i,
  input  logic [BYTE_W-1:0] ext8_data_i,
  input  logic              ext16_en_i,
  input  logic [WIDX_W-1:0] ext16_idx_i,
  input  logic [WORD_W-1:0] ext16_data_i,
  output logic              wr8_en_o,
  output logic [IDX_W-1:0]  wr8_idx_o,
  output logic [BYTE_W-1:0] wr8_data_o,
  output logic              wr16_en_o,
  output logic [WIDX_W-1:0] wr16_idx_o,
  output logic [WORD_W-1:0] wr16_data_o
);
  always_comb begin
    wr8_en_o    = ext8_en_i;
    wr8_idx_o   = ext8_idx_i;
    wr8_data_o  = ext8_data_i;
    wr16_en_o   = ext16_en_i;
    wr16_idx_o  = ext16_idx_i;
    wr16_data_o = ext16_data_i;
    case (op_i)
      OP_NIB_LO: begin
        wr8_en_o   = 1'b1;
        wr8_idx_o  = IDX_ACC;
        wr8_data_o = {acc_i[BYTE_W-1:NIB_W], operand_i};
        wr16_en_o  = 1'b0;
      end
      OP_NIB_HI: begin
        wr8_en_o   = 1'b1;
        wr8_idx_o  = IDX_ACC;
        wr8_data_o = {operand_i, acc_i[BYTE_W-NIB_W-1:0]};
        wr16_en_o  = 1'b0;
      end
      OP_MOV_A: begin
        wr8_en_o   = 1'b1;
        wr8_idx_o  = operand_i;
        wr8_data_o = acc_i;
        wr16_en_o  = 1'b0;
      end
      OP_MOV_W: begin
        wr8_en_o    = 1'b0;
        wr16_en_o   = 1'b1;
        wr16_idx_o  = operand_i[3:2];
        wr16_data_o = wsrc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/regfile_alias_bank.sv
module regfile_alias_bank
  import regfile_alias_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [IDX_W-1:0]                 wr_idx_i,
  input  logic [BYTE_W-1:0]                wr_data_i,
  input  logic [1:0]                       pair_we_i,
  input  logic [WORD_W-1:0]                pair_data_i,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]  regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    if (MY_IDX == IDX_ZERO) begin : g_zero
      assign regs_o[i] = '0;
    end else begin : g_store
      localparam int  OFS     = i - int'(IDX_PAIR0);
      localparam bit  IN_PAIR = (OFS >= 0) && (OFS < 4);
      localparam int  PSEL    = IN_PAIR ? OFS / 2 : 0;
      localparam bit  IS_HI   = IN_PAIR && ((OFS % 2) == 0);
      logic              en;
      logic [BYTE_W-1:0] d;
      logic [BYTE_W-1:0] q;

      always_comb begin
        en = 1'b0;
        d  = wr_data_i;
        if (wr_en_i && (wr_idx_i == MY_IDX)) begin
          en = 1'b1;
        end
        if (IN_PAIR && pair_we_i[PSEL]) begin
          en = 1'b1;
          d  = IS_HI ? pair_data_i[WORD_W-1:BYTE_W] : pair_data_i[BYTE_W-1:0];
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (en) begin
          q <= d;
        end
      end

      assign regs_o[i] = q;
    end
  end
endmodule

// File: rtl/regfile_alias_wide.sv
module regfile_alias_wide
  import regfile_alias_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WIDX_W-1:0] wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] sp_o
);
  logic pc_en, sp_en;
  logic [WORD_W-1:0] pc_q, sp_q;

  always_comb begin
    pc_en = wr_en_i && (wr_idx_i == W_PC);
    sp_en = wr_en_i && (wr_idx_i == W_SP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= wr_data_i;
    end
  end

  assign pc_o = pc_q;
  assign sp_o = sp_q;
endmodule

// File: rtl/regfile_alias.sv
module regfile_alias
  import regfile_alias_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned WORD_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [3:0]        operand_i,
  input  logic              wr8_en_i,
  input  logic [3:0]        wr8_idx_i,
  input  logic [BYTE_W-1:0] wr8_data_i,
  input  logic              wr16_en_i,
  input  logic [1:0]        wr16_idx_i,
  input  logic [WORD_W-1:0] wr16_data_i,
  input  logic [3:0]        rd8_idx_i,
  output logic [BYTE_W-1:0] rd8_data_o,
  input  logic [1:0]        rd16_idx_i,
  output logic [WORD_W-1:0] rd16_data_o,
  output logic [BYTE_W-1:0] acc_o,
  output logic [BYTE_W-1:0] flags_o
);
  localparam int unsigned P0 = IDX_PAIR0;

  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;
  logic [WORD_W-1:0] pc, sp, wsrc;
  logic              w8_en, w16_en;
  logic [IDX_W-1:0]  w8_idx;
  logic [WIDX_W-1:0] w16_idx;
  logic [BYTE_W-1:0] w8_data;
  logic [WORD_W-1:0] w16_data;
  logic [1:0]        pair_we;

  always_comb begin
    case (operand_i[1:0])
      W_PC:    wsrc = pc;
      W_SP:    wsrc = sp;
      W_IJ:    wsrc = {regs[P0],   regs[P0+1]};
      default: wsrc = {regs[P0+2], regs[P0+3]};
    endcase
  end

  regfile_alias_op #(.BYTE_W(BYTE_W)) op_i0 (
    .op_i        (op_i),
    .operand_i   (operand_i),
    .acc_i       (regs[IDX_ACC]),
    .wsrc_i      (wsrc),
    .ext8_en_i   (wr8_en_i),
    .ext8_idx_i  (wr8_idx_i),
    .ext8_data_i (wr8_data_i),
    .ext16_en_i  (wr16_en_i),
    .ext16_idx_i (wr16_idx_i),
    .ext16_data_i(wr16_data_i),
    .wr8_en_o    (w8_en),
    .wr8_idx_o   (w8_idx),
    .wr8_data_o  (w8_data),
    .wr16_en_o   (w16_en),
    .wr16_idx_o  (w16_idx),
    .wr16_data_o (w16_data)
  );

  always_comb begin
    pair_we[0] = w16_en && (w16_idx == W_IJ);
    pair_we[1] = w16_en && (w16_idx == W_KL);
  end

  regfile_alias_bank #(.BYTE_W(BYTE_W)) bank_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (w8_en),
    .wr_idx_i   (w8_idx),
    .wr_data_i  (w8_data),
    .pair_we_i  (pair_we),
    .pair_data_i(w16_data),
    .regs_o     (regs)
  );

  regfile_alias_wide #(.WORD_W(WORD_W)) wide_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (w16_en),
    .wr_idx_i (w16_idx),
    .wr_data_i(w16_data),
    .pc_o     (pc),
    .sp_o     (sp)
  );

  always_comb begin
    rd8_data_o = regs[rd8_idx_i];
    case (rd16_idx_i)
      W_PC:    rd16_data_o = pc;
      W_SP:    rd16_data_o = sp;
      W_IJ:    rd16_data_o = {regs[P0],   regs[P0+1]};
      default: rd16_data_o = {regs[P0+2], regs[P0+3]};
    endcase
    acc_o   = regs[IDX_ACC];
    flags_o = regs[IDX_FLAGS];
  end
endmodule

// File: rtl/regfile_alias_chk.sv
module regfile_alias_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [2:0]  op_i,
  input logic [3:0]  operand_i,
  input logic        wr8_en_i,
  input logic [3:0]  wr8_idx_i,
  input logic [7:0]  wr8_data_i,
  input logic        wr16_en_i,
  input logic [1:0]  wr16_idx_i,
  input logic [3:0]  rd8_idx_i,
  input logic [7:0]  rd8_data_o,
  input logic [1:0]  rd16_idx_i,
  input logic [15:0] rd16_data_o,
  input logic [7:0]  acc_o,
  input logic [7:0]  flags_o
);
  logic ext_mode, overlap, plain8;

  always_comb begin
    ext_mode = (op_i == 3'd0) || (op_i > 3'd4);
    overlap  = wr16_en_i &&
               (((wr16_idx_i == 2'd2) && (wr8_idx_i == 4'd8  || wr8_idx_i == 4'd9)) ||
                ((wr16_idx_i == 2'd3) && (wr8_idx_i == 4'd10 || wr8_idx_i == 4'd11)));
    plain8   = ext_mode && wr8_en_i && (wr8_idx_i != 4'd15) && !overlap;
  end

  p_zero_reads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd8_idx_i == 4'd15) |-> (rd8_data_o == 8'd0));

  p_byte_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(plain8) && (rd8_idx_i == $past(wr8_idx_i)))
      |-> (rd8_data_o == $past(wr8_data_i)));

  p_pair_alias_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd16_idx_i == 2'd2) && (rd8_idx_i == 4'd9)) |-> (rd16_data_o[7:0] == rd8_data_o));

  p_nib_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i == 3'd1))
      |-> ((acc_o[3:0] == $past(operand_i)) && (acc_o[7:4] == $past(acc_o[7:4]))));

  p_nib_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i == 3'd2))
      |-> ((acc_o[7:4] == $past(operand_i)) && (acc_o[3:0] == $past(acc_o[3:0]))));

  p_wide_move_ignores_ext_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(op_i == 3'd4)) |-> ($stable(acc_o) && $stable(flags_o)));

  p_acc_view_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd8_idx_i == 4'd0) |-> (rd8_data_o == acc_o));

  p_idle_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!wr8_en_i && !wr16_en_i && op_i == 3'd0))
      |-> ($stable(acc_o) && $stable(flags_o)));
endmodule

bind regfile_alias regfile_alias_chk chk_i (.*);

// File: tb/regfile_alias_tb.sv
`timescale 1ns/100ps
module regfile_alias_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [2:0]  op;
  logic [3:0]  opnd;
  logic        w8_en;
  logic [3:0]  w8_idx;
  logic [7:0]  w8_data;
  logic        w16_en;
  logic [1:0]  w16_idx;
  logic [15:0] w16_data;
  logic [3:0]  r8_idx;
  logic [7:0]  r8_data;
  logic [1:0]  r16_idx;
  logic [15:0] r16_data;
  logic [7:0]  acc, flags;

  logic [7:0]  m8 [16];
  logic [15:0] mpc, msp;
  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  regfile_alias dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .operand_i(opnd),
    .wr8_en_i(w8_en), .wr8_idx_i(w8_idx), .wr8_data_i(w8_data),
    .wr16_en_i(w16_en), .wr16_idx_i(w16_idx), .wr16_data_i(w16_data),
    .rd8_idx_i(r8_idx), .rd8_data_o(r8_data),
    .rd16_idx_i(r16_idx), .rd16_data_o(r16_data),
    .acc_o(acc), .flags_o(flags)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m16(int s);
    case (s)
      0:       return mpc;
      1:       return msp;
      2:       return {m8[8], m8[9]};
      default: return {m8[10], m8[11]};
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m8[i] = 8'h00;
    mpc = 16'h0;
    msp = 16'h0;
  endtask

  task automatic check_all(string req);
    for (int i = 0; i < 16; i++) begin
      r8_idx = 4'(i);
      #0.5;
      chk(req, $sformatf("byte[%0d]", i), {8'h00, r8_data}, {8'h00, m8[i]});
    end
    for (int w = 0; w < 4; w++) begin
      r16_idx = 2'(w);
      #0.5;
      chk(req, $sformatf("word[%0d]", w), r16_data, m16(w));
    end
    chk(req, "acc_o", {8'h00, acc}, {8'h00, m8[0]});
    chk(req, "flags_o", {8'h00, flags}, {8'h00, m8[5]});
  endtask

  task automatic model_wide_write(int idx, logic [15:0] d);
    case (idx)
      0: mpc = d;
      1: msp = d;
      2: begin m8[8]  = d[15:8]; m8[9]  = d[7:0]; end
      default: begin m8[10] = d[15:8]; m8[11] = d[7:0]; end
    endcase
  endtask

  task automatic cycle(int o, int od, bit e8, int i8, logic [7:0] d8,
                       bit e16, int i16, logic [15:0] d16);
    logic [15:0] src;
    @(negedge clk);
    op = 3'(o); opnd = 4'(od);
    w8_en = e8; w8_idx = 4'(i8); w8_data = d8;
    w16_en = e16; w16_idx = 2'(i16); w16_data = d16;
    src = m16(od & 3);
    case (o)
      1: m8[0] = {m8[0][7:4], 4'(od)};
      2: m8[0] = {4'(od), m8[0][3:0]};
      3: if (od != 15) m8[od] = m8[0];
      4: model_wide_write(od >> 2, src);
      default: begin
        if (e8 && i8 != 15) m8[i8] = d8;
        if (e16) model_wide_write(i16, d16);
      end
    endcase
    @(posedge clk);
    #1;
    op = 3'd0; w8_en = 1'b0; w16_en = 1'b0;
  endtask

  task automatic seed_wide();
    for (int w = 0; w < 4; w++) cycle(0, 0, 0, 0, 8'h00, 1, w, 16'h1000 * (w + 1) + 16'h0111 * (w + 3));
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    op = 0; opnd = 0; w8_en = 0; w8_idx = 0; w8_data = 0;
    w16_en = 0; w16_idx = 0; w16_data = 0; r8_idx = 0; r16_idx = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all("R1");

    // R2 / R3: byte write sweep over all indices
    for (int i = 0; i < 16; i++) begin
      cycle(0, 0, 1, i, 8'(8'h11 * i) ^ 8'hA5, 0, 0, 16'h0);
      check_all(i == 15 ? "R3" : "R2");
    end

    // R4 / R5: word write sweep
    for (int w = 0; w < 4; w++) begin
      cycle(0, 0, 0, 0, 8'h00, 1, w, 16'h1234 + 16'(w) * 16'h1111);
      check_all(w < 2 ? "R4" : "R5");
    end
    cycle(0, 0, 1, 9, 8'h3E, 0, 0, 16'h0);
    check_all("R5");
    cycle(0, 0, 1, 10, 8'hD1, 0, 0, 16'h0);
    check_all("R5");

    // R6: same-cycle byte and word writes
    cycle(0, 0, 1, 8, 8'h77, 1, 2, 16'hBEEF);
    check_all("R6");
    cycle(0, 0, 1, 11, 8'h44, 1, 3, 16'hCAFE);
    check_all("R6");
    cycle(0, 0, 1, 3, 8'h3C, 1, 3, 16'h5AA5);
    check_all("R6");
    cycle(0, 0, 1, 10, 8'h99, 1, 0, 16'h7E57);
    check_all("R6");

    // R7: nibble loads, every immediate
    for (int v = 0; v < 16; v++) begin
      cycle(1, v, 0, 0, 8'h00, 0, 0, 16'h0);
      check_all("R7");
      cycle(2, 15 - v, 0, 0, 8'h00, 0, 0, 16'h0);
      check_all("R7");
    end

    // R8: copy accumulator to every index
    for (int d = 0; d < 16; d++) begin
      cycle(1, d, 0, 0, 8'h00, 0, 0, 16'h0);
      cycle(2, 4'hC ^ 4'(d), 0, 0, 8'h00, 0, 0, 16'h0);
      cycle(3, d, 0, 0, 8'h00, 0, 0, 16'h0);
      check_all("R8");
    end

    // R9: word copy, every destination/source pair
    for (int o = 0; o < 16; o++) begin
      seed_wide();
      cycle(4, o, 0, 0, 8'h00, 0, 0, 16'h0);
      check_all("R9");
    end

    // R10: operations mask external writes; codes 5..7 pass them
    for (int o = 1; o < 8; o++) begin
      cycle(o, 6, 1, 2, 8'h60 + 8'(o), 1, 1, 16'hF00D + 16'(o));
      check_all("R10");
    end

    // R11: flags view
    cycle(0, 0, 1, 5, 8'hC3, 0, 0, 16'h0);
    check_all("R11");
    chk("R11", "flags_o direct", {8'h00, flags}, 16'h00C3);

    // R12: idle cycle with garbage data
    cycle(0, 9, 0, 4, 8'hFF, 0, 2, 16'hFFFF);
    check_all("R12");

    // mixed random traffic
    for (int k = 0; k < 300; k++) begin
      cycle(int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 15)), 8'($urandom),
            1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), 16'($urandom));
      check_all("R6");
    end

    // R1: reset later in the run, seen while asserted
    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    #0.5;
    check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check_all("R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule